// File: doc/BRIEF.md
# Video capture mode controller

This block decides which incoming video frames a capture engine stores. A host writes a five-bit mode word that holds a colour-mode code, a single-frame request and a continuous-run request. The video input parser supplies one-cycle strobes that mark where each frame begins and ends. The controller turns these into a capture window that always covers whole frames. Capture never starts or stops partway through a frame.

A single-frame request clears itself in the mode word once its frame has been stored. If continuous run and single-frame are both requested, continuous run wins. The colour-mode code is sampled only at a frame start, so pixel conversion never changes scheme within a frame. Two status flags are provided for the host to read: one shows continuous running and one shows a single frame in progress. An output-enable signal drops whenever the latched colour code is not a legal one.

Top module: `vcap_mode_ctrl`

## Requirements
- R1: After reset the mode readback is 0x14 (colour code 3'b101, both requests clear). `capture_active`, `stat_running` and `stat_single` are 0, `color_mode` is 3'b101 and `out_enable` is 1.
- R2: Mode word layout: bit 0 is the run request, bit 1 is the single-frame request, and bits 4..2 are the colour code. A host write replaces the whole word on the cycle after `mode_wr`.
- R3: A capture begins only at a `frame_start` strobe that is seen while the run request or the single-frame request is set. A request that arrives mid-frame waits for the next `frame_start`.
- R4: `capture_active` goes high the cycle after an accepted `frame_start`. It stays high until it goes low the cycle after the next `frame_end`.
- R5: Clearing the run request during a captured frame does not cut that frame short. No later frame is captured unless a request is set again.
- R6: When a frame that was started by the single-frame request alone ends, bit 1 of the mode readback reads 0 on the next cycle. A frame started while run was set leaves bit 1 unchanged, because run has priority over single-frame.
- R7: `stat_single` is high exactly when `capture_active` is high, the single-frame request is set and the run request is clear.
- R8: `stat_running` takes the value of the run request at each `frame_start`, and holds it between frame starts.
- R9: `color_mode` takes bits 4..2 of the mode word at each `frame_start`. A write between frame starts has no effect on `color_mode` until the next one.
- R10: `out_enable` is 0 when `color_mode` is 3'b000 or 3'b111, and 1 for every other code.
- R11: A `frame_end` strobe while no capture is active changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Host write strobe for the mode word |
| mode_wdata | input | 5 | Mode word to write |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| frame_end | input | 1 | One-cycle strobe at the end of a frame |
| mode_q | output | 5 | Mode word readback, including the self-cleared request |
| capture_active | output | 1 | High while the current frame is being stored |
| stat_running | output | 1 | Continuous-run status, refreshed at frame start |
| stat_single | output | 1 | Single frame in progress |
| color_mode | output | 3 | Colour code in use for the current frame |
| out_enable | output | 1 | Low when the colour code in use is illegal |

## Verification
The bench builds the block with its default parameters: a three-bit colour code and a reset mode word of 0x14. These values bring every colour code within reach, including the two illegal ones, and make the reset readback a fixed value the bench can predict. All four combinations of the two request bits are driven against frame strobes. This covers request changes in mid-frame and a strobe that ends a frame while no capture is running.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int CM_W   = 3;
  localparam int MODE_W = CM_W + 2;

  typedef enum logic {ST_IDLE, ST_CAP} cap_state_t;

  function automatic logic run_bit(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction

  function automatic logic sfc_bit(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic [CM_W-1:0] cm_field(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:2];
  endfunction

  // legal colour codes exclude all-zeros and all-ones
  function automatic logic cm_is_valid(input logic [CM_W-1:0] c);
    return (c != '0) && (c != '1);
  endfunction
endpackage

// File: rtl/vcap_mode_reg.sv
module vcap_mode_reg
  import vcap_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              sf_clear,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= RESET_MODE;
    else if (wr)       mode_q <= wdata;
    else if (sf_clear) mode_q[1] <= 1'b0;
  end

  // R6
  sf_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_clear && !wr) |=> !sfc_bit(mode_q));
endmodule

// File: rtl/vcap_frame_fsm.sv
module vcap_frame_fsm
  import vcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic sfc_req,
  input  logic frame_start,
  input  logic frame_end,
  output logic cap_active,
  output logic sf_done,
  output logic running
);
  cap_state_t state;
  logic       single_kind;
  logic       accept;

  assign accept     = (state == ST_IDLE) && frame_start && (run_req || sfc_req);
  assign cap_active = (state == ST_CAP);
  assign sf_done    = cap_active && frame_end && single_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      single_kind <= 1'b0;
    end else if (accept) begin
      state       <= ST_CAP;
      single_kind <= !run_req;
    end else if (cap_active && frame_end) begin
      state       <= ST_IDLE;
      single_kind <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           running <= 1'b0;
    else if (frame_start) running <= run_req;
  end

  // R3
  start_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_active) |-> $past(frame_start));
  // R4
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_active && frame_end) |=> !cap_active);
  // R5
  hold_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_active && !frame_end) |=> cap_active);
  // R8
  running_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(running));
endmodule

// File: rtl/vcap_cm_latch.sv
module vcap_cm_latch
  import vcap_pkg::*;
#(
  parameter logic [CM_W-1:0] RESET_CM = 3'b101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [CM_W-1:0] cm_in,
  output logic [CM_W-1:0] cm_active,
  output logic            out_enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cm_active <= RESET_CM;
    else if (frame_start) cm_active <= cm_in;
  end

  assign out_enable = cm_is_valid(cm_active);

  // R9
  cm_frame_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cm_active));
endmodule

// File: rtl/vcap_mode_ctrl.sv
module vcap_mode_ctrl
  import vcap_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [MODE_W-1:0] mode_q,
  output logic              capture_active,
  output logic              stat_running,
  output logic              stat_single,
  output logic [CM_W-1:0]   color_mode,
  output logic              out_enable
);
  localparam logic [CM_W-1:0] RESET_CM = RESET_MODE[MODE_W-1:2];

  logic sf_done;

  vcap_mode_reg #(.RESET_MODE(RESET_MODE)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata),
    .sf_clear(sf_done), .mode_q(mode_q)
  );

  vcap_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .run_req(run_bit(mode_q)), .sfc_req(sfc_bit(mode_q)),
    .frame_start(frame_start), .frame_end(frame_end),
    .cap_active(capture_active), .sf_done(sf_done), .running(stat_running)
  );

  vcap_cm_latch #(.RESET_CM(RESET_CM)) u_cm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cm_in(cm_field(mode_q)), .cm_active(color_mode), .out_enable(out_enable)
  );

  assign stat_single = capture_active && sfc_bit(mode_q) && !run_bit(mode_q);

  // R7
  single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_single |-> (capture_active && !run_bit(mode_q)));
  // R11
  idle_end_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_active && frame_end && !frame_start) |=> !capture_active);
endmodule

// File: tb/vcap_mode_ctrl_test.sv
module vcap_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [4:0] mode_wdata = '0;
  logic       frame_start = 1'b0;
  logic       frame_end = 1'b0;
  logic [4:0] mode_q;
  logic       capture_active, stat_running, stat_single, out_enable;
  logic [2:0] color_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vcap_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .frame_start(frame_start), .frame_end(frame_end), .mode_q(mode_q),
    .capture_active(capture_active), .stat_running(stat_running),
    .stat_single(stat_single), .color_mode(color_mode), .out_enable(out_enable)
  );

  // {wr, wdata[4:0], fs, fe, exp_act, exp_run, exp_single, exp_mode[4:0]}
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 5'h16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h16}, // R2 write sfc
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h16}, // R11 idle end
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'h16}, // R3 R7 single start
    {1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'h16}, // R4
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h14}, // R6 self clear
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h14}, // R3 no request
    {1'b1, 5'h15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h15}, // R3 run mid-frame waits
    {1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h15}, // R3
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'h15}, // R8 run start
    {1'b1, 5'h14, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h14}, // R5 clear run mid-frame
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h14}, // R5 frame finishes
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h14}, // R5 R8 no next frame
    {1'b1, 5'h17, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h17}, // R2 both bits
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'h17}, // R7 run priority
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h17}, // R6 no clear under run
    {1'b1, 5'h16, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'h16}, // R2
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'h16}, // R8 R7 single
    {1'b1, 5'h17, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'h17}, // R7 run set in frame
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h15}, // R6 single kind clears
    {1'b0, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'h15}, // R4 R8
    {1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'h15}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [4:0] d, input logic fs, input logic fe);
    mode_wr = wr; mode_wdata = d; frame_start = fs; frame_end = fe;
    @(negedge clk);
    mode_wr = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", {mode_q, capture_active, stat_running, stat_single, color_mode, out_enable},
          {5'h14, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1});

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15], VEC[i][14:10], VEC[i][9], VEC[i][8]);
      check($sformatf("R2-R8 vec%0d", i),
            {capture_active, stat_running, stat_single, mode_q},
            {VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:0]});
    end

    // colour latching, no requests set
    step(1'b1, 5'b000_00, 1'b0, 1'b0);
    check("R9 write no effect", {color_mode, out_enable}, {3'b101, 1'b1});
    step(1'b0, 5'h00, 1'b1, 1'b0);
    check("R10 code 000", {color_mode, out_enable}, {3'b000, 1'b0});
    step(1'b1, 5'b111_00, 1'b0, 1'b0);
    check("R9 hold 000", color_mode, 3'b000);
    step(1'b0, 5'h00, 1'b1, 1'b0);
    check("R10 code 111", {color_mode, out_enable}, {3'b111, 1'b0});
    step(1'b1, 5'b001_00, 1'b0, 1'b0);
    step(1'b0, 5'h00, 1'b1, 1'b0);
    check("R10 code 001", {color_mode, out_enable}, {3'b001, 1'b1});
    check("R3 no capture with requests clear", capture_active, 1'b0);
    // R11: end strobe while idle
    step(1'b0, 5'h00, 1'b0, 1'b1);
    check("R11", {capture_active, stat_running, color_mode, mode_q}, {1'b0, 1'b0, 3'b001, 5'b001_00});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule